// File: doc/BRIEF.md
# Fair-Rotation Interrupt Dispatcher

This block gathers up to 64 level-sensitive interrupt lines from on-chip peripherals. It samples them every cycle into a status register and qualifies them with a software enable mask. The qualified set is called the pending set. An OR of the pending set drives one registered interrupt line toward the CPU. Software reaches the status and mask through a small register bus. Besides full 32-bit mask words, the bus offers a single-bit operation that sets or clears one enable bit and leaves every other bit untouched.

When the CPU's handler pulses a dispatch request, the block names exactly one pending source. No source has a fixed priority. A stored search pointer marks where the next scan starts, and after every successful dispatch it moves to one past the source just served, so every active line gets its turn. A configurable index window can be marked as carrying cascaded external interrupts. A source inside that window is reported as external and renumbered from the window's lower edge. Any other source is reported as internal with its raw index.

Top module: `irq_rr_dispatch`

## Requirements
- R1: After reset the enable mask reads all zeros, the CPU line is low, and the search pointer is 0, so the first dispatch with every source pending reports source 0.
- R2: The status register holds the interrupt lines as sampled at the previous clock edge. Status low (bits 31:0) reads at address 0 and status high (bits 63:32) at address 1. Writes to these addresses have no effect on what they return.
- R3: A write to address 2 loads mask bits 31:0 and a write to address 3 loads mask bits 63:32. Both words read back at the same addresses from the next cycle on.
- R4: A write to address 4 changes one mask bit. The index is in data bits 5:0, and data bit 7 selects set (1) or clear (0). All other mask bits keep their values.
- R5: The CPU line equals the OR of (status AND mask) as it stood one clock earlier.
- R6: Every dispatch request gets a one-cycle done strobe in the next cycle. Its found flag is high exactly when the pending set was non-empty at the request edge.
- R7: The reported source is the first pending index at or above the pointer, searching upward and wrapping modulo the source count.
- R8: After a found dispatch the pointer becomes the reported index plus one, modulo the source count. A dispatch that finds nothing leaves it unchanged.
- R9: With cascading enabled, a reported index inside the inclusive window [WIN_LO, WIN_HI] gives the external flag set and a number equal to the index minus WIN_LO. Any other index gives the external flag clear and a number equal to the index.
- R10: A mask write that coincides with a dispatch request takes effect after that dispatch. The dispatch judges the mask as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | NUM_SRC | Level interrupt lines from peripherals |
| busEn | input | 1 | Register access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register address (0..4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, 0 when not reading |
| dispReq | input | 1 | Dispatch request pulse |
| dispDone | output | 1 | Dispatch answer strobe, one cycle after the request |
| dispFound | output | 1 | A pending source was chosen |
| dispSrc | output | log2(NUM_SRC) | Raw index of the chosen source |
| dispExt | output | 1 | Chosen source lies in the cascade window |
| dispNum | output | log2(NUM_SRC) | Remapped number (external or internal) |
| cpuIrq | output | 1 | Registered combined interrupt toward the CPU |

## Verification
A mask update and a dispatch can land on the same clock edge. The bench provokes this in two ways. It clears the enable of the only pending source in the very cycle it requests a dispatch. It also mixes random mask writes and single-bit operations with random dispatch requests. The reference model applies the write only after it has evaluated the dispatch, so a correct design still reports the source being disabled in that cycle. The next dispatch then finds nothing, and the pointer must not move.

// File: rtl/irq_rr_pkg.sv
package irq_rr_pkg;
  // Strobes from the control module to the datapath, one cycle wide each.
  typedef struct packed {
    logic wrMaskLo;
    logic wrMaskHi;
    logic bitSet;
    logic bitClr;
    logic take;
  } ctrl_t;

  localparam logic [2:0] ADDR_STAT_LO = 3'd0;
  localparam logic [2:0] ADDR_STAT_HI = 3'd1;
  localparam logic [2:0] ADDR_MASK_LO = 3'd2;
  localparam logic [2:0] ADDR_MASK_HI = 3'd3;
  localparam logic [2:0] ADDR_BIT_OP  = 3'd4;
endpackage

// File: rtl/irq_rr_datapath.sv
module irq_rr_datapath
  import irq_rr_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int CASCADE_EN = 1,
  parameter int WIN_LO     = 20,
  parameter int WIN_HI     = 25
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         irqLines,
  input  ctrl_t                      strb,
  input  logic [31:0]                wdata,
  output logic [63:0]                statusFull,
  output logic [63:0]                maskFull,
  output logic [NUM_SRC-1:0]         pendVec,
  output logic                       cpuIrq,
  output logic                       dispFound,
  output logic [$clog2(NUM_SRC)-1:0] dispSrc,
  output logic                       dispExt,
  output logic [$clog2(NUM_SRC)-1:0] dispNum
);
  localparam int PTR_W = $clog2(NUM_SRC);
  localparam logic [PTR_W-1:0] WLO = PTR_W'(WIN_LO);
  localparam logic [PTR_W-1:0] WHI = PTR_W'(WIN_HI);

  logic [NUM_SRC-1:0] status, mask, rot;
  logic [PTR_W-1:0]   ptr, off, sel;
  logic [63:0]        maskNext64;
  logic               anyPend, inWin;

  assign pendVec    = status & mask;
  assign anyPend    = |pendVec;
  assign statusFull = 64'(status);
  assign maskFull   = 64'(mask);

  // Rotate the pending set so the pointer position sits at bit 0.
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      logic [PTR_W-1:0] j;
      j = PTR_W'(i) + ptr;
      rot[i] = pendVec[j];
    end
  end

  // Lowest set bit of the rotated vector.
  always_comb begin
    off = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (rot[i]) off = PTR_W'(i);
    end
  end

  assign sel   = ptr + off;
  assign inWin = (CASCADE_EN != 0) && (sel >= WLO) && (sel <= WHI);

  always_comb begin
    maskNext64 = maskFull;
    if (strb.wrMaskLo) maskNext64[31:0]  = wdata;
    if (strb.wrMaskHi) maskNext64[63:32] = wdata;
    if (strb.bitSet)   maskNext64[wdata[5:0]] = 1'b1;
    if (strb.bitClr)   maskNext64[wdata[5:0]] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status    <= '0;
      mask      <= '0;
      ptr       <= '0;
      cpuIrq    <= 1'b0;
      dispFound <= 1'b0;
      dispSrc   <= '0;
      dispExt   <= 1'b0;
      dispNum   <= '0;
    end else begin
      status <= irqLines;
      mask   <= maskNext64[NUM_SRC-1:0];
      cpuIrq <= anyPend;
      if (strb.take) begin
        dispFound <= anyPend;
        if (anyPend) begin
          dispSrc <= sel;
          dispExt <= inWin;
          dispNum <= inWin ? (sel - WLO) : sel;
          ptr     <= sel + PTR_W'(1);
        end else begin
          dispSrc <= '0;
          dispExt <= 1'b0;
          dispNum <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/irq_rr_control.sv
module irq_rr_control
  import irq_rr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busEn,
  input  logic        busWe,
  input  logic [2:0]  busAddr,
  input  logic        opSet,
  input  logic        dispReq,
  input  logic [63:0] statusFull,
  input  logic [63:0] maskFull,
  output ctrl_t       strb,
  output logic [31:0] busRdata,
  output logic        dispDone
);
  logic wrEn, rdEn;

  assign wrEn = busEn && busWe;
  assign rdEn = busEn && !busWe;

  always_comb begin
    strb          = '0;
    strb.wrMaskLo = wrEn && (busAddr == ADDR_MASK_LO);
    strb.wrMaskHi = wrEn && (busAddr == ADDR_MASK_HI);
    strb.bitSet   = wrEn && (busAddr == ADDR_BIT_OP) && opSet;
    strb.bitClr   = wrEn && (busAddr == ADDR_BIT_OP) && !opSet;
    strb.take     = dispReq;
  end

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      case (busAddr)
        ADDR_STAT_LO: busRdata = statusFull[31:0];
        ADDR_STAT_HI: busRdata = statusFull[63:32];
        ADDR_MASK_LO: busRdata = maskFull[31:0];
        ADDR_MASK_HI: busRdata = maskFull[63:32];
        default:      busRdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dispDone <= 1'b0;
    else       dispDone <= dispReq;
  end
endmodule

// File: rtl/irq_rr_dispatch.sv
module irq_rr_dispatch
  import irq_rr_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int CASCADE_EN = 1,
  parameter int WIN_LO     = 20,
  parameter int WIN_HI     = 25
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         irqLines,
  input  logic                       busEn,
  input  logic                       busWe,
  input  logic [2:0]                 busAddr,
  input  logic [31:0]                busWdata,
  output logic [31:0]                busRdata,
  input  logic                       dispReq,
  output logic                       dispDone,
  output logic                       dispFound,
  output logic [$clog2(NUM_SRC)-1:0] dispSrc,
  output logic                       dispExt,
  output logic [$clog2(NUM_SRC)-1:0] dispNum,
  output logic                       cpuIrq
);
  ctrl_t              strb;
  logic [63:0]        statusFull, maskFull;
  logic [NUM_SRC-1:0] pendVec;

  irq_rr_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busEn      (busEn),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .opSet      (busWdata[7]),
    .dispReq    (dispReq),
    .statusFull (statusFull),
    .maskFull   (maskFull),
    .strb       (strb),
    .busRdata   (busRdata),
    .dispDone   (dispDone)
  );

  irq_rr_datapath #(
    .NUM_SRC    (NUM_SRC),
    .CASCADE_EN (CASCADE_EN),
    .WIN_LO     (WIN_LO),
    .WIN_HI     (WIN_HI)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .irqLines   (irqLines),
    .strb       (strb),
    .wdata      (busWdata),
    .statusFull (statusFull),
    .maskFull   (maskFull),
    .pendVec    (pendVec),
    .cpuIrq     (cpuIrq),
    .dispFound  (dispFound),
    .dispSrc    (dispSrc),
    .dispExt    (dispExt),
    .dispNum    (dispNum)
  );
endmodule

// File: rtl/irq_rr_checker.sv
module irq_rr_checker #(
  parameter int NUM_SRC    = 64,
  parameter int CASCADE_EN = 1,
  parameter int WIN_LO     = 20,
  parameter int WIN_HI     = 25
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       dispReq,
  input logic                       dispDone,
  input logic                       dispFound,
  input logic [$clog2(NUM_SRC)-1:0] dispSrc,
  input logic                       dispExt,
  input logic [$clog2(NUM_SRC)-1:0] dispNum,
  input logic                       cpuIrq,
  input logic [NUM_SRC-1:0]         pendVec
);
  localparam int PTR_W = $clog2(NUM_SRC);
  localparam logic [PTR_W-1:0] WLO = PTR_W'(WIN_LO);
  localparam logic [PTR_W-1:0] WHI = PTR_W'(WIN_HI);

  p_cpu_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cpuIrq == $past(|pendVec)));

  p_done_follows_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    dispReq |=> dispDone);

  p_no_spurious_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dispReq |=> !dispDone);

  p_found_matches_pend_r6: assert property (@(posedge clk) disable iff (!rstN)
    dispReq |=> (dispFound == $past(|pendVec)));

  p_chosen_is_pending_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dispReq && (|pendVec)) |=> (($past(pendVec) >> dispSrc) & 1) != 0);

  p_window_remap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dispDone && dispFound && dispExt) |->
      (CASCADE_EN != 0 && dispSrc >= WLO && dispSrc <= WHI && dispNum == dispSrc - WLO));

  p_internal_number_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dispDone && dispFound && !dispExt) |-> (dispNum == dispSrc));
endmodule

bind irq_rr_dispatch irq_rr_checker #(
  .NUM_SRC    (NUM_SRC),
  .CASCADE_EN (CASCADE_EN),
  .WIN_LO     (WIN_LO),
  .WIN_HI     (WIN_HI)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dispReq   (dispReq),
  .dispDone  (dispDone),
  .dispFound (dispFound),
  .dispSrc   (dispSrc),
  .dispExt   (dispExt),
  .dispNum   (dispNum),
  .cpuIrq    (cpuIrq),
  .pendVec   (pendVec)
);

// File: tb/sim_irq_rr_dispatch.sv
`timescale 1ns/1ps
module sim_irq_rr_dispatch;
  localparam int N   = 64;
  localparam int PW  = 6;
  localparam int WLO = 20;
  localparam int WHI = 25;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  irqLines = '0;
  logic          busEn = 1'b0, busWe = 1'b0;
  logic [2:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          dispReq = 1'b0;
  logic          dispDone, dispFound, dispExt, cpuIrq;
  logic [PW-1:0] dispSrc, dispNum;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // reference model state
  logic [63:0] mStat = '0, mMask = '0;
  int mPtr = 0;

  always #4 clk = ~clk;

  irq_rr_dispatch #(.NUM_SRC(N), .CASCADE_EN(1), .WIN_LO(WLO), .WIN_HI(WHI)) u0 (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .busEn(busEn), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .dispReq(dispReq),
    .dispDone(dispDone), .dispFound(dispFound), .dispSrc(dispSrc), .dispExt(dispExt),
    .dispNum(dispNum), .cpuIrq(cpuIrq));

  task automatic check(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  // One clock: evaluate model from current state and inputs, advance, compare.
  task automatic step();
    logic [63:0] pend, nMask;
    bit eCpu, eFound, eDone, eExt;
    int eSrc, eNum, eNextPtr;
    pend = mStat & mMask;
    eCpu = |pend;
    eDone = dispReq;
    eFound = 0; eSrc = 0; eExt = 0; eNum = 0; eNextPtr = mPtr;
    if (dispReq && eCpu) begin
      eFound = 1;
      for (int k = 0; k < N; k++) begin
        int idx;
        idx = (mPtr + k) % N;
        if (pend[idx]) begin eSrc = idx; break; end
      end
      eExt = (eSrc >= WLO) && (eSrc <= WHI);
      eNum = eExt ? eSrc - WLO : eSrc;
      eNextPtr = (eSrc + 1) % N;
    end
    nMask = mMask;
    if (busEn && busWe) begin
      case (busAddr)
        3'd2: nMask[31:0] = busWdata;
        3'd3: nMask[63:32] = busWdata;
        3'd4: nMask[busWdata[5:0]] = busWdata[7];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    mStat = irqLines;
    mMask = nMask;
    mPtr = eNextPtr;
    check("R5", "cpuIrq", cpuIrq, eCpu);
    check("R6", "dispDone", dispDone, eDone);
    if (eDone) begin
      check("R6", "dispFound", dispFound, eFound);
      if (eFound) begin
        check("R7", "dispSrc", dispSrc, eSrc);
        check("R9", "dispExt", dispExt, eExt);
        check("R9", "dispNum", dispNum, eNum);
      end
    end
  endtask

  task automatic rd(logic [2:0] a, string req);
    logic [63:0] exp;
    busEn = 1; busWe = 0; busAddr = a;
    #1;
    case (a)
      3'd0: exp = {32'b0, mStat[31:0]};
      3'd1: exp = {32'b0, mStat[63:32]};
      3'd2: exp = {32'b0, mMask[31:0]};
      3'd3: exp = {32'b0, mMask[63:32]};
      default: exp = 0;
    endcase
    check(req, "busRdata", busRdata, exp);
    busEn = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, bit withDisp);
    busEn = 1; busWe = 1; busAddr = a; busWdata = d; dispReq = withDisp;
    step();
    busEn = 0; busWe = 0; dispReq = 0;
  endtask

  task automatic disp();
    dispReq = 1;
    step();
    dispReq = 0;
  endtask

  initial begin
    #(8ns * 200000);
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    check("R1", "cpuIrq", cpuIrq, 0);
    rd(3'd2, "R1"); rd(3'd3, "R1");
    irqLines = '1;
    step(); step();
    disp(); // mask all zero: nothing found (R6)
    check("R8", "ptr kept, no source", dispFound, 0);
    wr(3'd2, 32'hFFFF_FFFF, 0); // R3
    wr(3'd3, 32'hFFFF_FFFF, 0);
    rd(3'd2, "R3"); rd(3'd3, "R3");
    disp(); // R1: pointer 0 → source 0
    check("R1", "first source", dispSrc, 0);
    disp(); check("R8", "advance", dispSrc, 1);
    // R2: status readback and write ignored
    irqLines = 64'hA5A5_0000_1234_5678;
    step();
    rd(3'd0, "R2"); rd(3'd1, "R2");
    wr(3'd0, 32'hDEAD_BEEF, 0); wr(3'd1, 32'hCAFE_F00D, 0);
    rd(3'd0, "R2"); rd(3'd1, "R2");
    // R4: single-bit ops
    wr(3'd2, 32'h0, 0); wr(3'd3, 32'h0, 0);
    wr(3'd4, 32'h0000_00BF, 0); // set bit 63
    wr(3'd4, 32'h0000_0080, 0); // set bit 0
    wr(3'd4, 32'h0000_0096, 0); // set bit 22
    wr(3'd4, 32'h0000_0000, 0); // clear bit 0
    rd(3'd2, "R4"); rd(3'd3, "R4");
    // R9 window + R7 wrap: only 22 and 63 enabled, all lines high
    irqLines = '1;
    step();
    disp(); check("R9", "window src", dispSrc, 22);
    check("R9", "ext num", dispNum, 2);
    disp(); check("R7", "next upward", dispSrc, 63);
    disp(); check("R7", "wrap", dispSrc, 22);
    // R10: clear the only pending source in the dispatch cycle
    wr(3'd4, 32'h0000_003F, 0); // clear 63, only 22 left
    wr(3'd4, 32'h0000_0016, 1); // clear 22 while dispatching
    check("R10", "old mask used", dispFound, 1);
    check("R10", "source", dispSrc, 22);
    disp(); check("R10", "now empty", dispFound, 0);
    // R8: pointer unchanged after empty dispatch (was 23)
    wr(3'd4, 32'h0000_0085, 0); // set 5
    wr(3'd4, 32'h0000_00A8, 0); // set 40
    disp(); check("R8", "ptr held", dispSrc, 40);
    // random phase
    for (int c = 0; c < 3000; c++) begin
      int r;
      irqLines = {$urandom, $urandom};
      r = $urandom_range(0, 9);
      busEn = 0; busWe = 0; dispReq = ($urandom_range(0, 1) == 1);
      if (r < 2) begin
        busEn = 1; busWe = 1; busAddr = 3'($urandom_range(0, 4));
        busWdata = $urandom;
      end
      step();
      busEn = 0; busWe = 0; dispReq = 0;
      if (r == 9) rd(3'($urandom_range(0, 3)), "R3");
    end
    finish_run();
  end
endmodule